// File: doc/BRIEF.md
# Receive Character FIFO with Error-Status Lock

This block holds received characters for a serial controller until the host or a DMA engine collects them. Each slot stores one data byte and, beside it, the three error flags the deserializer raised for that byte. The character in the exit slot is always shown on the read outputs, with its flags, so software can inspect the error state before it consumes the byte. A read strobe removes the data and its flags together.

When a flagged character is read and the current receive interrupt mode calls for locking, the FIFO does not advance. The flagged byte and its flags stay in the exit slot, further reads return the same byte, and the DMA request drops. An error-reset command discards that byte, clears the lock and lets normal reads continue. In the all-characters mode, and when receive interrupts are off, flagged bytes leave the FIFO like any other byte.

Top module: `rx_lock_fifo`

## Requirements
- R1: After reset, `empty`=1, `count`=0, `locked`=0 and `dma_req`=0.
- R2: Bytes leave in arrival order. `count` goes up by one for each accepted push and down by one for each removed byte. `empty` is 1 exactly when `count` is 0.
- R3: `rd_data` and `rd_stat` always show the byte in the exit slot and its own flags. The flags are parity error in bit 0, overrun in bit 1 and end-of-frame in bit 2. A pop removes the byte and its flags together.
- R4: A character is special when any of its flag bits is set. If `pop` is applied to a special exit character while `mode` is 2'b01 (first-character) or 2'b11 (special-only), the character stays in the exit slot, `count` is unchanged and `locked` becomes 1 on the next cycle.
- R5: While `locked` is 1, `pop` has no effect. `rd_data`, `rd_stat` and the exit slot stay unchanged, and `locked` stays 1 until an error reset.
- R6: `err_reset` while `locked` is 1 clears `locked` and discards the exit character on the same edge. It takes priority over a `pop` in the same cycle.
- R7: In `mode` 2'b10 (all characters) or 2'b00 (receive interrupts off), a special character is removed by `pop` like any other and no lock is set.
- R8: A push into a full FIFO is dropped, `count` stays at the depth, and the overrun flag (bit 1) is set on the most recently stored entry.
- R9: `dma_req` is 1 exactly when the FIFO is not empty and not locked.
- R10: `pop` on an empty FIFO has no effect.
- R11: A push while `locked` is 1 is stored behind the locked character and does not change the exit slot.
- R12: `err_reset` while `locked` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Receive interrupt mode: 00 off, 01 first-character, 10 all characters, 11 special-only |
| push_valid | input | 1 | Deserializer delivers a byte this cycle |
| push_data | input | 8 | Received byte |
| push_stat | input | 3 | Flags of the received byte (bit 0 parity, bit 1 overrun, bit 2 end-of-frame) |
| pop | input | 1 | Read strobe from host or DMA |
| err_reset | input | 1 | Error-reset command |
| rd_data | output | 8 | Byte in the exit slot |
| rd_stat | output | 3 | Flags of the byte in the exit slot |
| empty | output | 1 | No byte stored |
| count | output | 4 | Number of stored bytes |
| locked | output | 1 | FIFO frozen on a special character |
| dma_req | output | 1 | DMA may read a byte |

## Verification
Every result is registered once. A push, pop or error reset applied before an edge is visible on `count`, `empty`, `locked`, `dma_req`, `rd_data` and `rd_stat` just after that edge, with no second cycle of delay. The bench applies one command per cycle and samples two time units after the following rising edge, so each check sees exactly that edge's effect. The lock cases step through mode changes, repeated reads, pushes while locked and a read together with an error reset in the same cycle. Each step is checked against an expected state written out in a table.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int STAT_W = 3;
  localparam int ST_PAR = 0;
  localparam int ST_OVR = 1;
  localparam int ST_EOF = 2;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_FIRST   = 2'b01,
    MODE_ALL     = 2'b10,
    MODE_SPECIAL = 2'b11
  } rx_mode_e;

  // a character carries a special condition when any flag is raised
  function automatic logic is_special(input logic [STAT_W-1:0] s);
    return |s;
  endfunction

  // only the first-character and special-only modes freeze the FIFO
  function automatic logic mode_locks(input logic [1:0] m);
    return (m == MODE_FIRST) || (m == MODE_SPECIAL);
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int STAT_W = 3,
  parameter int OVR_BIT = 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STAT_W-1:0] wr_stat,
  input  logic              rd_en,
  input  logic              ovr_mark,
  output logic [DATA_W-1:0] head_data,
  output logic [STAT_W-1:0] head_stat,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
  endfunction

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [STAT_W-1:0] stat_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [PTR_W-1:0]  newest;

  assign newest = ptr_prev(wr_ptr);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[i] <= '0;
        stat_q[i] <= '0;
      end else if (wr_en && wr_ptr == PTR_W'(i)) begin
        data_q[i] <= wr_data;
        stat_q[i] <= wr_stat;
      end else if (ovr_mark && newest == PTR_W'(i)) begin
        stat_q[i][OVR_BIT] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= ptr_next(wr_ptr);
      if (rd_en) rd_ptr <= ptr_next(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign head_data = data_q[rd_ptr];
  assign head_stat = stat_q[rd_ptr];
  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
endmodule

// File: rtl/rxf_lock_ctl.sv
module rxf_lock_ctl
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              pop,
  input  logic              err_reset,
  input  logic              empty,
  input  logic [STAT_W-1:0] head_stat,
  output logic              locked,
  output logic              take,
  output logic              lock_set,
  output logic              unlock
);
  logic pop_ok;
  logic freeze_hit;

  assign pop_ok     = pop && !empty && !locked;
  assign freeze_hit = mode_locks(mode) && is_special(head_stat);
  assign lock_set   = pop_ok && freeze_hit;
  assign unlock     = locked && err_reset;
  assign take       = (pop_ok && !freeze_hit) || unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b0;
    else if (unlock)   locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
  end
endmodule

// File: rtl/rxf_admit.sv
module rxf_admit (
  input  logic push_valid,
  input  logic full,
  input  logic take,
  output logic wr_en,
  output logic ovr_mark
);
  // a slot freed on the same edge makes room for the incoming byte
  assign wr_en    = push_valid && (!full || take);
  assign ovr_mark = push_valid && full && !take;
endmodule

// File: rtl/rx_lock_fifo.sv
module rx_lock_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic [STAT_W-1:0] push_stat,
  input  logic              pop,
  input  logic              err_reset,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] rd_stat,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic              locked,
  output logic              dma_req
);
  logic full;
  logic take;
  logic lock_set;
  logic unlock;
  logic wr_en;
  logic ovr_mark;

  rxf_lock_ctl u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .pop       (pop),
    .err_reset (err_reset),
    .empty     (empty),
    .head_stat (rd_stat),
    .locked    (locked),
    .take      (take),
    .lock_set  (lock_set),
    .unlock    (unlock)
  );

  rxf_admit u_admit (
    .push_valid (push_valid),
    .full       (full),
    .take       (take),
    .wr_en      (wr_en),
    .ovr_mark   (ovr_mark)
  );

  rxf_store #(
    .DEPTH   (DEPTH),
    .DATA_W  (DATA_W),
    .STAT_W  (STAT_W),
    .OVR_BIT (ST_OVR)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (push_data),
    .wr_stat   (push_stat),
    .rd_en     (take),
    .ovr_mark  (ovr_mark),
    .head_data (rd_data),
    .head_stat (rd_stat),
    .count     (count),
    .full      (full),
    .empty     (empty)
  );

  assign dma_req = !empty && !locked;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              push_valid,
  input logic              err_reset,
  input logic [DATA_W-1:0] rd_data,
  input logic [2:0]        rd_stat,
  input logic              empty,
  input logic [CNT_W-1:0]  count,
  input logic              locked,
  input logic              dma_req,
  input logic              take,
  input logic              lock_set
);
  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (count == '0)); // R2
  AST_LOCK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> locked); // R4
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !err_reset) |=> (locked && $stable(rd_data) && $stable(rd_stat))); // R5
  AST_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && err_reset) |=> !locked); // R6
  AST_NO_LOCK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && (mode == 2'b10 || mode == 2'b00)) |=> !locked); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R8
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && push_valid && !take) |=> count == CNT_W'(DEPTH)); // R8
  AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req == (!empty && !locked)); // R9
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_valid) |=> empty); // R10
endmodule

bind rx_lock_fifo rxf_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .push_valid (push_valid),
  .err_reset  (err_reset),
  .rd_data    (rd_data),
  .rd_stat    (rd_stat),
  .empty      (empty),
  .count      (count),
  .locked     (locked),
  .dma_req    (dma_req),
  .take       (take),
  .lock_set   (lock_set)
);

// File: tb/tb_rx_lock_fifo.sv
module tb_rx_lock_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic [2:0] push_stat = '0;
  logic       pop = 1'b0;
  logic       err_reset = 1'b0;
  logic [7:0] rd_data;
  logic [2:0] rd_stat;
  logic       empty;
  logic [3:0] count;
  logic       locked;
  logic       dma_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_lock_fifo dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .push_valid(push_valid),
    .push_data(push_data), .push_stat(push_stat), .pop(pop),
    .err_reset(err_reset), .rd_data(rd_data), .rd_stat(rd_stat),
    .empty(empty), .count(count), .locked(locked), .dma_req(dma_req)
  );

  typedef struct packed {
    logic       pu;
    logic [7:0] d;
    logic [2:0] s;
    logic       po;
    logic       er;
    logic [1:0] m;
    logic [3:0] e_cnt;
    logic       e_lock;
    logic [7:0] e_d;
    logic [2:0] e_s;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hA1, 3'b000, 1'b0, 1'b0, 2'b01, 4'd1, 1'b0, 8'hA1, 3'b000}, // R2 push
    '{1'b1, 8'hB2, 3'b001, 1'b0, 1'b0, 2'b01, 4'd2, 1'b0, 8'hA1, 3'b000}, // R2
    '{1'b1, 8'hC3, 3'b000, 1'b0, 1'b0, 2'b01, 4'd3, 1'b0, 8'hA1, 3'b000}, // R2
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 2'b01, 4'd2, 1'b0, 8'hB2, 3'b001}, // R3 clean pop
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 2'b01, 4'd2, 1'b1, 8'hB2, 3'b001}, // R4 lock
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 2'b01, 4'd2, 1'b1, 8'hB2, 3'b001}, // R5 reread
    '{1'b1, 8'hD4, 3'b100, 1'b0, 1'b0, 2'b01, 4'd3, 1'b1, 8'hB2, 3'b001}, // R11
    '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 2'b01, 4'd2, 1'b0, 8'hC3, 3'b000}, // R6
    '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 2'b01, 4'd2, 1'b0, 8'hC3, 3'b000}, // R12
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 2'b10, 4'd1, 1'b0, 8'hD4, 3'b100}, // R3
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 2'b10, 4'd0, 1'b0, 8'h00, 3'b000}, // R7
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 2'b10, 4'd0, 1'b0, 8'h00, 3'b000}, // R10
    '{1'b1, 8'hE5, 3'b100, 1'b0, 1'b0, 2'b11, 4'd1, 1'b0, 8'hE5, 3'b100}, // R2
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 2'b11, 4'd1, 1'b1, 8'hE5, 3'b100}, // R4 special-only
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 2'b11, 4'd0, 1'b0, 8'h00, 3'b000}  // R6 priority
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic pu, input logic [7:0] d, input logic [2:0] s,
                      input logic po, input logic er, input logic [1:0] m);
    push_valid = pu; push_data = d; push_stat = s;
    pop = po; err_reset = er; mode = m;
    @(posedge clk);
    #2;
    push_valid = 1'b0; pop = 1'b0; err_reset = 1'b0;
  endtask

  task automatic chk_flags(input string req, input int e_cnt, input bit e_lock);
    chk(count == 4'(e_cnt), {req, " count"}, count, e_cnt);
    chk(locked == e_lock, {req, " locked"}, locked, e_lock);
    chk(empty == (e_cnt == 0), {req, " empty"}, empty, e_cnt == 0);
    chk(dma_req == (e_cnt != 0 && !e_lock), "R9 dma_req", dma_req, e_cnt != 0 && !e_lock);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk_flags("R1", 0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #2;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].pu, VEC[i].d, VEC[i].s, VEC[i].po, VEC[i].er, VEC[i].m);
      chk_flags($sformatf("R2/R4 row %0d", i), VEC[i].e_cnt, VEC[i].e_lock);
      if (VEC[i].e_cnt != 0) begin
        chk(rd_data == VEC[i].e_d, $sformatf("R3 row %0d data", i), rd_data, VEC[i].e_d);
        chk(rd_stat == VEC[i].e_s, $sformatf("R3 row %0d stat", i), rd_stat, VEC[i].e_s);
      end
    end

    // R8: fill, overflow, then drain in order
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'h10 + 8'(i), 3'b000, 1'b0, 1'b0, 2'b10);
    chk_flags("R8 full", DEPTH, 1'b0);
    step(1'b1, 8'hFF, 3'b000, 1'b0, 1'b0, 2'b10);
    chk_flags("R8 drop", DEPTH, 1'b0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      chk(rd_data == 8'h10 + 8'(i), "R2 order", rd_data, 8'h10 + i);
      chk(rd_stat == 3'b000, "R8 older flags clean", rd_stat, 0);
      step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 2'b10);
    end
    chk(rd_data == 8'h17, "R8 newest kept", rd_data, 8'h17);
    chk(rd_stat == 3'b010, "R8 overrun flag", rd_stat, 3'b010);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 2'b10);
    chk_flags("R7 flagged byte leaves in all mode", 0, 1'b0);

    // R1: reset while locked with content
    step(1'b1, 8'h5A, 3'b100, 1'b0, 1'b0, 2'b01);
    step(1'b1, 8'h6B, 3'b000, 1'b0, 1'b0, 2'b01);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 2'b01);
    chk_flags("R4 eof lock", 2, 1'b1);
    chk(rd_data == 8'h5A, "R5 held byte", rd_data, 8'h5A);
    #1 rst_n = 1'b0;
    @(posedge clk); #2;
    chk_flags("R1 reset mid-run", 0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #2;

    finish_run();
  end
endmodule